// File: doc/BRIEF.md
# Chunked Vector Sum Reduction Engine

The engine adds up `len` signed 32-bit words held in memory from byte address `base` and returns one 32-bit scalar. It cannot assume the whole list fits its internal lane buffer. It therefore walks the list in chunks. The size of each chunk is the smaller of the lane count `LANES` and the number of words still to be read. Words are fetched one per cycle through a read port with one cycle of latency and placed in the lane buffer. The chunk is then folded into a scalar accumulator that carries over from one chunk to the next. The accumulator starts at zero for every job.

Two fold orders are available, chosen per job by `tree_mode`. In serial order, the words are added to the accumulator strictly by index, one per cycle. In tree order, the lanes are summed pairwise, halving the live width each cycle, and the final lane-0 sum is then added to the accumulator in one more cycle. Addition wraps modulo 2^32, so both orders give the same answer. Tree order is faster when chunks are long.

Top module: `vredsum_unit`

## Requirements
- R1: While reset is held and after reset is released, `busy`, `done`, `mem_rd` and `result` are all 0.
- R2: Reads come in bursts of back-to-back `mem_rd` cycles. Each burst is one chunk, and its length equals min(`LANES`, words not yet read). This holds for any power-of-two `LANES` from 1 to 16.
- R3: The k-th read of a job (k counted from 0) presents byte address `base` + 4*k, so addresses ascend. A job issues exactly `len` reads.
- R4: With `tree_mode`=0, `result` equals the sum of the `len` words modulo 2^32.
- R5: With `tree_mode`=1, `result` is the same wrapped sum as in serial order.
- R6: With `tree_mode`=0, `done` rises T cycles after the edge that samples `start`. T is the sum over chunks of (2*VL + 4), where VL is that chunk's length.
- R7: With `tree_mode`=1, T is the sum over chunks of (VL + 5 + ceil(log2 VL)).
- R8: If `len`=0 when `start` is sampled, `done` is high in the next cycle with `result`=0. No read is issued and `busy` stays 0.
- R9: A `start` raised while `busy` is 1 has no effect on the running job's reads, result or timing.
- R10: `done` is high for exactly one cycle per job, and `busy` is 0 in that cycle. `result` holds its value from the `done` cycle until the next job's `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job; sampled only while idle |
| len | input | NW | Number of words to sum |
| base | input | AW | Byte address of word 0 |
| tree_mode | input | 1 | 0 = serial fold, 1 = pairwise tree fold |
| mem_rd | output | 1 | Read request |
| mem_addr | output | AW | Read byte address |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DW | Wrapped sum of the last job |

## Verification
The checker relies on three properties of the environment. Reset is held for at least two edges. The memory answers every request exactly one cycle later. A new `start` is never raised in the cycle right after `done`, since a zero-length job started there would produce a second `done` pulse back to back. The bench meets all three: it holds reset for five cycles, models the memory as a registered function of the address, and waits several idle cycles between jobs. It sweeps `len` from 0 to 20 over three lane counts (1, 4 and 8) in both fold orders and from two base addresses. Some jobs also get a stray `start` pulse while the engine is busy.

// File: rtl/vred_pkg.sv
package vred_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_FILL,
    ST_FOLD,
    ST_STEP
  } vred_state_e;
endpackage

// File: rtl/vred_vlen.sv
module vred_vlen #(
  parameter int LANES = 8,
  parameter int NW    = 16,
  parameter int VW    = $clog2(LANES + 1)
) (
  input  logic [NW-1:0] remaining,
  output logic [VW-1:0] vl
);
  always_comb begin
    if (remaining >= NW'(LANES)) vl = VW'(LANES);
    else                         vl = VW'(remaining);
  end
endmodule

// File: rtl/vred_lanes.sv
module vred_lanes #(
  parameter int LANES = 8,
  parameter int DW    = 32,
  parameter int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          fold,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] lane  [LANES];
  logic [DW-1:0] halve [LANES];

  // one tree level: lane i takes the sum of lanes 2i and 2i+1
  for (genvar i = 0; i < LANES; i++) begin : g_lvl
    if (i < LANES / 2) begin : g_sum
      assign halve[i] = lane[2*i] + lane[2*i+1];
    end else if (LANES == 1) begin : g_keep
      assign halve[i] = lane[i];
    end else begin : g_zero
      assign halve[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (clr)                                  lane[i] <= '0;
      else if (wr_en && (wr_idx == IW'(i)))     lane[i] <= wr_data;
      else if (fold)                            lane[i] <= halve[i];
    end
  end

  assign rd_data = lane[rd_idx];
endmodule

// File: rtl/vredsum_unit.sv
module vredsum_unit #(
  parameter int LANES = 8,
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int NW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] len,
  input  logic [AW-1:0] base,
  input  logic          tree_mode,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);
  import vred_pkg::*;

  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int VW = $clog2(LANES + 1);

  vred_state_e   state;
  logic [NW-1:0] rem_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] acc_q;
  logic [VW-1:0] vl_now, vl_q, iss_q, wr_q, ridx_q, width_q;
  logic          rvld_q, mode_q;
  logic          rd_q, done_q;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] result_q;

  logic          lane_clr, lane_wr, lane_fold;
  logic [IW-1:0] lane_sel;
  logic [DW-1:0] lane_out;

  vred_vlen #(.LANES(LANES), .NW(NW), .VW(VW)) u_vlen (
    .remaining (rem_q),
    .vl        (vl_now)
  );

  assign lane_clr  = (state == ST_SETUP);
  assign lane_wr   = (state == ST_FILL) && rvld_q;
  assign lane_fold = (state == ST_FOLD) && mode_q && (width_q > VW'(1));
  assign lane_sel  = mode_q ? '0 : IW'(ridx_q);

  vred_lanes #(.LANES(LANES), .DW(DW), .IW(IW)) u_lanes (
    .clk     (clk),
    .clr     (lane_clr),
    .wr_en   (lane_wr),
    .wr_idx  (IW'(wr_q)),
    .wr_data (mem_rdata),
    .fold    (lane_fold),
    .rd_idx  (lane_sel),
    .rd_data (lane_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rem_q     <= '0;
      addr_q    <= '0;
      acc_q     <= '0;
      vl_q      <= '0;
      iss_q     <= '0;
      wr_q      <= '0;
      ridx_q    <= '0;
      width_q   <= '0;
      rvld_q    <= 1'b0;
      mode_q    <= 1'b0;
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
      done_q    <= 1'b0;
      result_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (len == '0) begin
              done_q   <= 1'b1;
              result_q <= '0;
            end else begin
              rem_q  <= len;
              addr_q <= base;
              acc_q  <= '0;
              mode_q <= tree_mode;
              state  <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          vl_q   <= vl_now;
          iss_q  <= '0;
          wr_q   <= '0;
          rvld_q <= 1'b0;
          state  <= ST_FILL;
        end
        ST_FILL: begin
          if (iss_q != vl_q) begin
            rd_q      <= 1'b1;
            rd_addr_q <= addr_q + (AW'(iss_q) << 2);
            iss_q     <= iss_q + VW'(1);
          end else begin
            rd_q <= 1'b0;
          end
          rvld_q <= rd_q;
          if (rvld_q) begin
            wr_q <= wr_q + VW'(1);
            if (wr_q == vl_q - VW'(1)) begin
              ridx_q  <= '0;
              width_q <= vl_q;
              state   <= ST_FOLD;
            end
          end
        end
        ST_FOLD: begin
          if (mode_q) begin
            if (width_q > VW'(1)) begin
              width_q <= VW'((width_q + VW'(1)) >> 1);
            end else begin
              acc_q <= acc_q + lane_out;
              state <= ST_STEP;
            end
          end else begin
            acc_q  <= acc_q + lane_out;
            ridx_q <= ridx_q + VW'(1);
            if (ridx_q == vl_q - VW'(1)) state <= ST_STEP;
          end
        end
        ST_STEP: begin
          addr_q <= addr_q + (AW'(vl_q) << 2);
          rem_q  <= rem_q - NW'(vl_q);
          if (rem_q == NW'(vl_q)) begin
            done_q   <= 1'b1;
            result_q <= acc_q;
            state    <= ST_IDLE;
          end else begin
            state <= ST_SETUP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign result   = result_q;
  assign mem_rd   = rd_q;
  assign mem_addr = rd_addr_q;
endmodule

// File: rtl/vredsum_unit_chk.sv
module vredsum_unit_chk #(
  parameter int LANES = 8,
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int NW    = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] result
);
  logic [7:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (mem_rd) run_q <= run_q + 8'd1;
    else             run_q <= '0;
  end

  // R2: no burst is longer than the lane count
  a_r2_burst_cap: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (run_q < 8'(LANES)));

  // R3: back-to-back reads step by one word
  a_r3_addr_stride: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(4)));

  // R8: reads are issued only inside a job
  a_r8_rd_in_job: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  // R10: completion is reported while idle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: the result changes only together with done
  a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

bind vredsum_unit vredsum_unit_chk #(
  .LANES(LANES), .DW(DW), .AW(AW), .NW(NW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .busy     (busy),
  .done     (done),
  .result   (result)
);

// File: tb/vredsum_unit_bench.sv
module vredsum_unit_bench;
  localparam int ND = 3;
  localparam int LV [ND] = '{1, 4, 8};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] len = '0;
  logic [31:0] base = '0;
  logic        tree_mode = 1'b0;

  logic        d_rd    [ND];
  logic [31:0] d_addr  [ND];
  logic [31:0] d_rdata [ND];
  logic        d_busy  [ND];
  logic        d_done  [ND];
  logic [31:0] d_res   [ND];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int cur_n, cur_base;
  int rd_cnt [ND], run [ND], addr_err [ND], burst_err [ND];
  int done_cnt [ND], done_at [ND];
  logic        done_seen [ND];
  logic [31:0] res_at [ND];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] memval(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F ^ (a >> 3);
  endfunction

  for (genvar g = 0; g < ND; g++) begin : g_dut
    vredsum_unit #(.LANES(LV[g]), .DW(32), .AW(32), .NW(16)) u_vredsum_unit (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .len       (len),
      .base      (base),
      .tree_mode (tree_mode),
      .mem_rd    (d_rd[g]),
      .mem_addr  (d_addr[g]),
      .mem_rdata (d_rdata[g]),
      .busy      (d_busy[g]),
      .done      (d_done[g]),
      .result    (d_res[g])
    );
    always @(posedge clk) if (d_rd[g]) d_rdata[g] <= memval(d_addr[g]);
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int g = 0; g < ND; g++) begin
        if (d_rd[g]) begin
          if (d_addr[g] != 32'(cur_base + 4 * rd_cnt[g])) addr_err[g]++;
          rd_cnt[g]++;
          run[g]++;
        end else if (run[g] > 0) begin
          int left, exp_vl;
          left   = cur_n - (rd_cnt[g] - run[g]);
          exp_vl = (left < LV[g]) ? left : LV[g];
          if (run[g] != exp_vl) burst_err[g]++;
          run[g] = 0;
        end
        if (d_done[g]) begin
          done_cnt[g]++;
          if (!done_seen[g]) begin
            done_seen[g] = 1'b1;
            done_at[g]   = cyc;
            res_at[g]    = d_res[g];
          end
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clg(input int v);
    int r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  function automatic int exp_lat(input int lanes, input int n, input logic tm);
    int rem = n, t = 0;
    while (rem > 0) begin
      int vl = (rem < lanes) ? rem : lanes;
      t += tm ? (vl + 5 + clg(vl)) : (2 * vl + 4);
      rem -= vl;
    end
    return t;
  endfunction

  task automatic run_job(input int n, input int b, input logic tm, input logic bump);
    int t0;
    logic [31:0] sum = '0;
    logic all_done;
    for (int k = 0; k < n; k++) sum += memval(32'(b + 4 * k));
    @(posedge clk); #2;
    cur_n = n; cur_base = b;
    for (int g = 0; g < ND; g++) begin
      rd_cnt[g] = 0; run[g] = 0; addr_err[g] = 0; burst_err[g] = 0;
      done_cnt[g] = 0; done_at[g] = -1; done_seen[g] = 1'b0;
    end
    len = 16'(n); base = 32'(b); tree_mode = tm; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    t0 = cyc;
    if (bump && n > 0) begin
      repeat (3) @(posedge clk);
      #2;
      len = 16'(n + 5); base = 32'(b + 64); tree_mode = ~tm; start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0; len = 16'(n); base = 32'(b); tree_mode = tm;
    end
    for (int w = 0; w < 3000; w++) begin
      all_done = 1'b1;
      for (int g = 0; g < ND; g++) if (!done_seen[g]) all_done = 1'b0;
      if (all_done) break;
      @(posedge clk); #2;
    end
    repeat (4) @(posedge clk);
    #2;
    for (int g = 0; g < ND; g++) begin
      string tr = tm ? "R5 tree sum" : "R4 serial sum";
      chk(res_at[g] == sum, bump ? "R9 sum after stray start" : tr, res_at[g], sum);
      chk(rd_cnt[g] == n, bump ? "R9 read count after stray start" : "R3 read count",
          rd_cnt[g], n);
      chk(addr_err[g] == 0, "R3 read addresses", addr_err[g], 0);
      chk(burst_err[g] == 0, "R2 chunk burst length", burst_err[g], 0);
      if (n == 0)
        chk(done_at[g] == t0, "R8 zero-length done timing", done_at[g] - t0, 0);
      else
        chk(done_at[g] - t0 == exp_lat(LV[g], n, tm), tm ? "R7 tree latency" : "R6 serial latency",
            done_at[g] - t0, exp_lat(LV[g], n, tm));
      chk(done_cnt[g] == 1, "R10 single done pulse", done_cnt[g], 1);
      chk(d_res[g] == res_at[g] && !d_busy[g], "R10 result held while idle", d_res[g], res_at[g]);
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int g = 0; g < ND; g++) begin
      rd_cnt[g] = 0; run[g] = 0; addr_err[g] = 0; burst_err[g] = 0;
      done_cnt[g] = 0; done_at[g] = -1; done_seen[g] = 1'b0; res_at[g] = '0;
    end
    cur_n = 0; cur_base = 0;
    repeat (5) @(posedge clk);
    #2;
    for (int g = 0; g < ND; g++)
      chk(!d_busy[g] && !d_done[g] && !d_rd[g] && d_res[g] == 0, "R1 reset state",
          {d_busy[g], d_done[g], d_rd[g]}, 0);
    rst = 1'b0;
    @(posedge clk); #2;
    for (int g = 0; g < ND; g++)
      chk(!d_busy[g] && !d_done[g] && !d_rd[g] && d_res[g] == 0, "R1 after reset release",
          {d_busy[g], d_done[g], d_rd[g]}, 0);

    for (int m = 0; m < 2; m++)
      for (int n = 0; n <= 20; n++) begin
        run_job(n, 32'h0000_1000, m[0], 1'b0);
        run_job(n, 32'h00A0_3F7C, m[0], 1'b0);
      end

    // R9: stray start pulses during busy jobs
    run_job(9, 32'h0000_2000, 1'b0, 1'b1);
    run_job(13, 32'h0000_2400, 1'b1, 1'b1);
    run_job(1, 32'h0000_2800, 1'b1, 1'b1);

    // R8: zero-length job issues no reads and never goes busy
    run_job(0, 32'h0000_3000, 1'b1, 1'b0);
    for (int g = 0; g < ND; g++)
      chk(rd_cnt[g] == 0 && !d_busy[g] && d_res[g] == 0, "R8 zero-length idle", rd_cnt[g], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule